// File: doc/BRIEF.md
# Dual TLB Index-Invalidate Controller

This block keeps the valid bits, tags and replacement state for two translation lookaside buffers, one serving instruction fetch and one serving data access. Each buffer is two-way set associative with 64 sets of 4 KiB pages. A request port with a valid/ready handshake accepts three kinds of maintenance operation: invalidate one set, synchronise with an external invalidate-in-progress signal, and invalidate everything. The last one is not supported, and the block reports it as an illegal instruction.

An index invalidate takes the set number from the effective address. It clears both ways of that set in both buffers in the same cycle. A sync operation does no work of its own. It holds the request port closed until the external busy input is seen low, then reports completion. A fill port and a lookup port let the surrounding logic load entries and probe them, so the effect of each invalidate can be seen. Software clears everything by issuing one invalidate for each set number 0 to 63 and then a sync.

Top module: `tlb_inval_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every valid bit and every replacement bit in both buffers. After reset, `req_ready` is 1 and `done_o` and `illegal_o` are 0.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. The opcode encodings are 0 for index invalidate, 1 for sync, 2 for invalidate-all and 3 for reserved. Each accepted request produces at most one of `done_o` and `illegal_o`.
- R3: An index invalidate takes its set index from `req_ea[17:12]`. It clears the valid bit of both ways of that set and leaves every other set unchanged.
- R4: One index invalidate acts on the instruction buffer and the data buffer in the same cycle.
- R5: `done_o` is a one-cycle pulse in the cycle after an index invalidate is accepted.
- R6: After a sync is accepted, `req_ready` is 0 until the sync completes. While `sync_busy_i` is 1, `done_o` stays 0. `done_o` pulses in the cycle after the first clock edge at which `sync_busy_i` is 0, and `req_ready` returns to 1 in that same cycle.
- R7: Opcodes 2 and 3 pulse `illegal_o` in the cycle after acceptance. They give no `done_o`, do not drop `req_ready`, and change no valid bit.
- R8: A fill (`fill_valid`, with `fill_sel` 0 for the instruction buffer and 1 for the data buffer) loads tag `fill_ea[31:18]` into set `fill_ea[17:12]`. It writes the way named by that set's replacement bit, marks that way valid, and points the replacement bit at the other way.
- R9: A lookup presented with `lk_valid` gives, in the next cycle, `lk_rsp_valid`=1 and `lk_hit`=1 with `lk_way` equal to the matching way when a valid way of set `lk_ea[17:12]` in the buffer chosen by `lk_sel` holds tag `lk_ea[31:18]`. Otherwise `lk_hit` is 0. A hit points that set's replacement bit at the other way.
- R10: A lookup presented in the cycle right after an index invalidate is accepted, to the same set, returns a miss in either buffer.
- R11: Invalidates for set indices 0 through 63 followed by a sync leave every entry of both buffers invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Maintenance request present |
| req_ready | output | 1 | Request port open; low while a sync waits |
| req_op | input | 2 | Opcode: 0 invalidate, 1 sync, 2 invalidate-all, 3 reserved |
| req_ea | input | 32 | Effective address; bits 17:12 select the set |
| sync_busy_i | input | 1 | External invalidate-in-progress indication |
| done_o | output | 1 | Completion pulse for invalidate or sync |
| illegal_o | output | 1 | Illegal-instruction pulse for opcode 2 or 3 |
| fill_valid | input | 1 | Load one entry |
| fill_sel | input | 1 | Fill target: 0 instruction, 1 data |
| fill_ea | input | 32 | Fill address: tag bits 31:18, set bits 17:12 |
| lk_valid | input | 1 | Lookup probe present |
| lk_sel | input | 1 | Lookup target: 0 instruction, 1 data |
| lk_ea | input | 32 | Lookup address |
| lk_rsp_valid | output | 1 | Lookup result valid, one cycle after probe |
| lk_hit | output | 1 | Lookup found a valid matching way |
| lk_way | output | 1 | Way that matched |

## Verification
The bench probes a set in the cycle right after its invalidate. A design that cleared the valid bits one cycle late would report a stale hit there. It also checks the data buffer after an invalidate sent through the shared port, which catches a design that cleared only the instruction side, and it probes a neighbouring set, which catches a decode of the wrong address bits. A sync is held with the busy input high for several cycles, so an early completion or a port that reopens too soon gets caught. Opcodes 2 and 3 are sent against a loaded set and must leave its hit in place. Replacement order is checked by refilling a set after a hit has moved its replacement bit.

// File: rtl/tlb_inval_pkg.sv
package tlb_inval_pkg;

  localparam int NUM_WAYS = 2;
  localparam int NUM_BUFS = 2;

  typedef enum logic [1:0] {
    OP_INVAL     = 2'd0,
    OP_SYNC      = 2'd1,
    OP_INVAL_ALL = 2'd2,
    OP_RSVD      = 2'd3
  } tlb_op_e;

  typedef enum logic {
    ST_IDLE      = 1'b0,
    ST_SYNC_WAIT = 1'b1
  } req_state_e;

endpackage

// File: rtl/tlb_req_ctrl.sv
module tlb_req_ctrl
  import tlb_inval_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_op,
  input  logic       sync_busy,
  output logic       req_ready,
  output logic       inv_en,
  output logic       done_o,
  output logic       illegal_o
);

  req_state_e state_q;
  tlb_op_e    op;
  logic       accept;

  assign op        = tlb_op_e'(req_op);
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign inv_en    = accept && (op == OP_INVAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            case (op)
              OP_INVAL: done_o    <= 1'b1;
              OP_SYNC:  state_q   <= ST_SYNC_WAIT;
              default:  illegal_o <= 1'b1;
            endcase
          end
        end
        ST_SYNC_WAIT: begin
          if (!sync_busy) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tlb_set_array.sv
module tlb_set_array
  import tlb_inval_pkg::*;
#(
  parameter int SETS_LG = 6,
  parameter int TAG_W   = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inv_en,
  input  logic [SETS_LG-1:0] inv_idx,
  input  logic               fill_en,
  input  logic [SETS_LG-1:0] fill_idx,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic               lk_en,
  input  logic [SETS_LG-1:0] lk_idx,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               hit_o,
  output logic               way_o
);

  localparam int SETS = 1 << SETS_LG;

  logic [SETS-1:0]     repl_q;
  logic                fill_way;
  logic [NUM_WAYS-1:0] way_hit;

  assign fill_way = repl_q[fill_idx];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  vld_q;
    logic             wr_here;

    assign wr_here = fill_en && (fill_way == w[0]);

    // tag storage: no reset, single write port
    always_ff @(posedge clk) begin
      if (wr_here) tag_mem[fill_idx] <= fill_tag;
    end

    // valid bits: invalidate takes priority over a fill to the same set
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= '0;
      end else begin
        if (wr_here) vld_q[fill_idx] <= 1'b1;
        if (inv_en)  vld_q[inv_idx]  <= 1'b0;
      end
    end

    assign way_hit[w] = vld_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);
  end

  assign hit_o = |way_hit;
  assign way_o = way_hit[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      repl_q <= '0;
    end else if (fill_en) begin
      repl_q[fill_idx] <= ~fill_way;
    end else if (lk_en && hit_o) begin
      repl_q[lk_idx] <= ~way_o;
    end
  end

endmodule

// File: rtl/tlb_inval_ctrl.sv
module tlb_inval_ctrl
  import tlb_inval_pkg::*;
#(
  parameter int EA_W     = 32,
  parameter int PAGE_LSB = 12,
  parameter int SETS_LG  = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_op,
  input  logic [EA_W-1:0] req_ea,
  input  logic            sync_busy_i,
  output logic            done_o,
  output logic            illegal_o,
  input  logic            fill_valid,
  input  logic            fill_sel,
  input  logic [EA_W-1:0] fill_ea,
  input  logic            lk_valid,
  input  logic            lk_sel,
  input  logic [EA_W-1:0] lk_ea,
  output logic            lk_rsp_valid,
  output logic            lk_hit,
  output logic            lk_way
);

  localparam int TAG_LSB = PAGE_LSB + SETS_LG;
  localparam int TAG_W   = EA_W - TAG_LSB;

  logic                inv_en;
  logic [SETS_LG-1:0]  inv_idx;
  logic [NUM_BUFS-1:0] buf_hit;
  logic [NUM_BUFS-1:0] buf_way;

  assign inv_idx = req_ea[PAGE_LSB +: SETS_LG];

  tlb_req_ctrl u_req (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .sync_busy (sync_busy_i),
    .req_ready (req_ready),
    .inv_en    (inv_en),
    .done_o    (done_o),
    .illegal_o (illegal_o)
  );

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
    tlb_set_array #(
      .SETS_LG (SETS_LG),
      .TAG_W   (TAG_W)
    ) u_arr (
      .clk      (clk),
      .rst      (rst),
      .inv_en   (inv_en),
      .inv_idx  (inv_idx),
      .fill_en  (fill_valid && (fill_sel == b[0])),
      .fill_idx (fill_ea[PAGE_LSB +: SETS_LG]),
      .fill_tag (fill_ea[TAG_LSB +: TAG_W]),
      .lk_en    (lk_valid && (lk_sel == b[0])),
      .lk_idx   (lk_ea[PAGE_LSB +: SETS_LG]),
      .lk_tag   (lk_ea[TAG_LSB +: TAG_W]),
      .hit_o    (buf_hit[b]),
      .way_o    (buf_way[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_rsp_valid <= 1'b0;
      lk_hit       <= 1'b0;
      lk_way       <= 1'b0;
    end else begin
      lk_rsp_valid <= lk_valid;
      lk_hit       <= lk_valid && buf_hit[lk_sel];
      lk_way       <= buf_way[lk_sel];
    end
  end

endmodule

// File: rtl/tlb_inval_ctrl_chk.sv
module tlb_inval_ctrl_chk #(
  parameter int EA_W     = 32,
  parameter int PAGE_LSB = 12,
  parameter int SETS_LG  = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      req_op,
  input logic [EA_W-1:0] req_ea,
  input logic            sync_busy_i,
  input logic            done_o,
  input logic            illegal_o,
  input logic            fill_valid,
  input logic            fill_sel,
  input logic [EA_W-1:0] fill_ea,
  input logic            lk_valid,
  input logic            lk_sel,
  input logic [EA_W-1:0] lk_ea,
  input logic            lk_rsp_valid,
  input logic            lk_hit,
  input logic            lk_way
);

  logic acc;
  assign acc = req_valid && req_ready;

  p_one_outcome_r2: assert property (@(posedge clk) disable iff (rst)
    !(done_o && illegal_o));

  p_inval_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (acc && req_op == 2'd0) |=> (done_o && !illegal_o));

  p_sync_closes_port_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && req_op == 2'd1) |=> !req_ready);

  p_sync_waits_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && sync_busy_i) |=> (!done_o && !req_ready));

  p_illegal_trap_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && req_op[1]) |=> (illegal_o && !done_o && req_ready));

  p_lookup_resp_r9: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> lk_rsp_valid);

  p_hit_needs_resp_r9: assert property (@(posedge clk) disable iff (rst)
    !lk_rsp_valid |-> !lk_hit);

  p_miss_after_inval_r10: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && $past(acc && req_op == 2'd0)
     && lk_ea[PAGE_LSB +: SETS_LG] == $past(req_ea[PAGE_LSB +: SETS_LG]))
    |=> !lk_hit);

endmodule

bind tlb_inval_ctrl tlb_inval_ctrl_chk #(
  .EA_W     (EA_W),
  .PAGE_LSB (PAGE_LSB),
  .SETS_LG  (SETS_LG)
) u_chk (.*);

// File: tb/tlb_inval_ctrl_bench.sv
module tlb_inval_ctrl_bench;

  localparam int SETS  = 64;
  localparam int TAG_W = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_ea = '0;
  logic        sync_busy_i = 1'b0;
  logic        done_o, illegal_o;
  logic        fill_valid = 1'b0;
  logic        fill_sel = 1'b0;
  logic [31:0] fill_ea = '0;
  logic        lk_valid = 1'b0;
  logic        lk_sel = 1'b0;
  logic [31:0] lk_ea = '0;
  logic        lk_rsp_valid, lk_hit, lk_way;

  always #10 clk = ~clk;

  tlb_inval_ctrl u_tlb_inval_ctrl (.*);

  int n_chk = 0;
  int n_err = 0;

  // reference model
  bit               mv [2][SETS][2];
  logic [TAG_W-1:0] mt [2][SETS][2];
  bit               ml [2][SETS];

  // scoreboard queues
  bit    q_hit[$];
  bit    q_way[$];
  string q_lreq[$];
  int    q_ev[$];   // 1 = done, 2 = illegal
  string q_ereq[$];

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ea(int idx, logic [TAG_W-1:0] tag);
    return {tag, idx[5:0], 12'h3C5};
  endfunction

  task automatic do_fill(int b, int idx, logic [TAG_W-1:0] tag);
    int w;
    fill_valid = 1'b1; fill_sel = b[0]; fill_ea = mk_ea(idx, tag);
    @(posedge clk); #1;
    fill_valid = 1'b0;
    w = ml[b][idx];
    mv[b][idx][w] = 1'b1; mt[b][idx][w] = tag; ml[b][idx] = ~w[0];
  endtask

  task automatic do_lookup(int b, int idx, logic [TAG_W-1:0] tag, string r);
    bit h = 1'b0;
    bit wy = 1'b0;
    for (int w = 0; w < 2; w++)
      if (mv[b][idx][w] && mt[b][idx][w] == tag) begin h = 1'b1; wy = w[0]; end
    if (h) ml[b][idx] = ~wy;
    q_hit.push_back(h); q_way.push_back(wy); q_lreq.push_back(r);
    lk_valid = 1'b1; lk_sel = b[0]; lk_ea = mk_ea(idx, tag);
    @(posedge clk); #1;
    lk_valid = 1'b0;
  endtask

  task automatic do_req(logic [1:0] op, int idx, string r);
    while (!req_ready) begin @(posedge clk); #1; end
    q_ev.push_back(op == 2'd0 ? 1 : 2); q_ereq.push_back(r);
    req_valid = 1'b1; req_op = op; req_ea = mk_ea(idx, 14'h2AB);
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (op == 2'd0)
      for (int b = 0; b < 2; b++) begin mv[b][idx][0] = 1'b0; mv[b][idx][1] = 1'b0; end
  endtask

  task automatic do_sync(int busy_cycles, string r);
    while (!req_ready) begin @(posedge clk); #1; end
    sync_busy_i = (busy_cycles > 0);
    q_ev.push_back(1); q_ereq.push_back(r);
    req_valid = 1'b1; req_op = 2'd1; req_ea = '0;
    @(posedge clk); #1;
    req_valid = 1'b0;
    for (int i = 0; i < busy_cycles; i++) begin
      @(negedge clk);
      chk(r, "ready while sync waits", req_ready, 0);
      chk(r, "done while busy high", done_o, 0);
      @(posedge clk); #1;
    end
    sync_busy_i = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    chk(r, "ready after sync completes", req_ready, 1);
    @(posedge clk); #1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (lk_rsp_valid) begin
        if (q_hit.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL R9 unexpected lookup response actual=1 expected=0");
        end else begin
          bit h, wy;
          string r;
          h = q_hit.pop_front(); wy = q_way.pop_front(); r = q_lreq.pop_front();
          chk(r, "lookup hit", lk_hit, h);
          if (h) chk(r, "lookup way", lk_way, wy);
        end
      end
      if (done_o || illegal_o) begin
        if (q_ev.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL R5/R7 unexpected completion actual=%0d%0d expected=00", done_o, illegal_o);
        end else begin
          int ev;
          string r;
          ev = q_ev.pop_front(); r = q_ereq.pop_front();
          chk(r, "done pulse", done_o, (ev == 1));
          chk(r, "illegal pulse", illegal_o, (ev == 2));
        end
      end
    end
  end

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R11 watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1", "ready after reset", req_ready, 1);
    chk("R1", "done after reset", done_o, 0);
    chk("R1", "illegal after reset", illegal_o, 0);
    chk("R1", "rsp after reset", lk_rsp_valid, 0);
    @(posedge clk); #1;
    do_lookup(0, 5, 14'h0000, "R1");
    do_lookup(1, 63, 14'h0000, "R1");

    // fill and replacement order
    do_fill(0, 5, 14'h1111);
    do_fill(0, 5, 14'h2222);
    do_fill(1, 5, 14'h3333);
    do_fill(1, 9, 14'h0444);
    do_lookup(0, 5, 14'h1111, "R8");
    do_lookup(0, 5, 14'h2222, "R8");
    do_lookup(1, 5, 14'h3333, "R9");
    do_lookup(0, 5, 14'h3333, "R9");
    do_lookup(1, 9, 14'h0444, "R9");
    do_fill(0, 5, 14'h0555);
    do_lookup(0, 5, 14'h1111, "R9");
    do_lookup(0, 5, 14'h0555, "R8");
    do_lookup(0, 5, 14'h2222, "R8");

    // index invalidate of set 5: both ways, both buffers, next-cycle miss
    do_req(2'd0, 5, "R5");
    do_lookup(0, 5, 14'h0555, "R10");
    do_lookup(0, 5, 14'h2222, "R3");
    do_lookup(1, 5, 14'h3333, "R4");
    do_lookup(1, 9, 14'h0444, "R3");

    // invalidate-all and reserved opcodes trap and keep state
    do_fill(1, 20, 14'h0666);
    do_fill(0, 20, 14'h0777);
    do_req(2'd2, 20, "R7");
    do_lookup(1, 20, 14'h0666, "R7");
    do_req(2'd3, 20, "R7");
    do_lookup(0, 20, 14'h0777, "R7");
    @(negedge clk);
    chk("R7", "ready after illegal", req_ready, 1);
    @(posedge clk); #1;

    // sync behaviour
    do_sync(4, "R6");
    do_sync(0, "R6");
    do_sync(1, "R2");

    // full clear sequence
    for (int s = 0; s < 8; s++) begin
      do_fill(0, s * 8 + 1, 14'h1000 + s[13:0]);
      do_fill(0, s * 8 + 1, 14'h2000 + s[13:0]);
      do_fill(1, s * 8 + 2, 14'h3000 + s[13:0]);
      do_fill(1, s * 8 + 2, 14'h0100 + s[13:0]);
    end
    do_lookup(0, 1, 14'h1000, "R8");
    do_lookup(1, 58, 14'h0107, "R8");
    for (int i = 0; i < SETS; i++) do_req(2'd0, i, "R11");
    do_sync(2, "R11");
    for (int s = 0; s < 8; s++) begin
      do_lookup(0, s * 8 + 1, 14'h1000 + s[13:0], "R11");
      do_lookup(0, s * 8 + 1, 14'h2000 + s[13:0], "R11");
      do_lookup(1, s * 8 + 2, 14'h3000 + s[13:0], "R11");
      do_lookup(1, s * 8 + 2, 14'h0100 + s[13:0], "R11");
    end
    do_lookup(1, 20, 14'h0666, "R11");

    repeat (3) @(posedge clk);
    #1;
    chk("R9", "lookup queue drained", q_hit.size(), 0);
    chk("R2", "event queue drained", q_ev.size(), 0);
    finish_run();
  end

endmodule